// File: doc/BRIEF.md
# Cycle-Faithful 16-Bit Multiplier

This block multiplies two 16-bit operands into a 32-bit product. Its completion time copies the timing of an older processor's word multiply instruction, so a cycle-accurate core model can use it directly. A start pulse captures the operands, a signed/unsigned select and a core-mode select. The block then stays busy for a number of cycles that is set entirely by the mode and the bit pattern of the source operand. A one-cycle done pulse marks the last busy cycle.

The latency is made up of a base cost chosen by mode and signedness, plus two cycles per "marked" bit of the source operand. In unsigned mode a marked bit is a one. In signed mode a marked bit is a position whose value differs from the bit below it. The product itself comes from a shift-add engine that needs fewer cycles than the shortest latency. The block also reports the total latency it charged, so the surrounding model can account for the time.

Top module: `mul16_timed`

## Requirements
- R1: With is_signed=0, the product is the 32-bit result of the zero-extended src times the zero-extended dst.
- R2: With is_signed=1, the product is the 32-bit two's-complement result of the sign-extended src times the sign-extended dst.
- R3: With core_mode=0 and is_signed=0, the latency is 38 + 2 × (number of ones in src).
- R4: With core_mode=0 and is_signed=1, the latency is 38 + 2 × (number of positions i in 0..15 where src[i] differs from src[i-1]), with src[-1] taken as 0.
- R5: With core_mode=1, the base is 32 when signed and 30 when unsigned, and the same source-dependent term as in R3/R4 is added.
- R6: With core_mode=2 or 3, the latency is a flat 27 cycles whatever the operands.
- R7: The dst operand never changes the latency.
- R8: The cycles output shows the latency of an accepted start from the cycle after acceptance, and holds it until the next accepted start.
- R9: busy is high for exactly latency consecutive cycles, starting in the cycle after acceptance. done is high in the last of those cycles only.
- R10: A start while busy is ignored: the running latency, cycles and product do not change, and no second operation follows.
- R11: Operands, is_signed and core_mode are captured at acceptance. Later changes to them have no effect on the running operation.
- R12: After reset, busy, done, product and cycles are all 0.
- R13: A zero src gives the base latency only, in both signed and unsigned modes, and a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a multiply; accepted when not busy |
| is_signed | input | 1 | 1: signed multiply, 0: unsigned |
| core_mode | input | 2 | Timing profile: 0 oldest, 1 second, 2/3 flat |
| src | input | 16 | Source operand; sets the data-dependent latency |
| dst | input | 16 | Destination operand |
| product | output | 32 | Result, valid when done is high, held until the next accepted start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse on the last busy cycle |
| cycles | output | 7 | Latency charged for the current or last operation |

## Verification
The hardest situations to reach from the ports are a start request that arrives partway through an operation, and input changes that arrive after capture. In both, the port-level behaviour must stay exactly as if nothing had happened. The bench starts a long operation, raises start with different operands and mode several cycles in, and then checks that the total busy length, the product and the reported cycle count all belong to the first operation and that busy stays low afterwards. It also changes every input in the first busy cycle. The extreme latencies come from alternating-bit sources in signed mode (0x5555 gives 70 cycles in the oldest mode), which the stimulus table runs in every mode and signedness.

// File: rtl/mul16_pkg.sv
package mul16_pkg;

   typedef enum logic [1:0] {
      CORE_OLDEST = 2'd0,
      CORE_SECOND = 2'd1,
      CORE_FLAT_A = 2'd2,
      CORE_FLAT_B = 2'd3
   } core_mode_e;

endpackage

// File: rtl/mul16_cost.sv
module mul16_cost
   import mul16_pkg::*;
#(
   parameter int OP_W        = 16,
   parameter int CNT_W       = 7,
   parameter int BASE_OLDEST = 38,
   parameter int BASE_SEC_S  = 32,
   parameter int BASE_SEC_U  = 30,
   parameter int BASE_FLAT   = 27,
   parameter int BIT_COST    = 2
) (
   input  logic [OP_W-1:0]  src,
   input  logic             sgn,
   input  core_mode_e       mode,
   output logic [CNT_W-1:0] total
);
   localparam int TAL_W = $clog2(OP_W + 1);

   logic [OP_W-1:0]  marks;
   logic [TAL_W-1:0] tally;
   logic [CNT_W-1:0] base_sel;
   logic [CNT_W-1:0] extra;

   // one mark per source bit: a one (unsigned) or a change from the bit below (signed)
   for (genvar i = 0; i < OP_W; i++) begin : g_mark
      if (i == 0) begin : g_lsb
         assign marks[i] = src[0];
      end else begin : g_upper
         assign marks[i] = sgn ? (src[i] ^ src[i-1]) : src[i];
      end
   end

   function automatic logic [TAL_W-1:0] tally_of(input logic [OP_W-1:0] v);
      logic [TAL_W-1:0] n;
      n = '0;
      for (int k = 0; k < OP_W; k++) n = n + TAL_W'(v[k]);
      return n;
   endfunction

   assign tally = tally_of(marks);

   always_comb begin
      base_sel = CNT_W'(BASE_FLAT);
      extra    = '0;
      unique case (mode)
         CORE_OLDEST: begin
            base_sel = CNT_W'(BASE_OLDEST);
            extra    = CNT_W'(BIT_COST) * CNT_W'(tally);
         end
         CORE_SECOND: begin
            base_sel = sgn ? CNT_W'(BASE_SEC_S) : CNT_W'(BASE_SEC_U);
            extra    = CNT_W'(BIT_COST) * CNT_W'(tally);
         end
         default: begin
            base_sel = CNT_W'(BASE_FLAT);
            extra    = '0;
         end
      endcase
   end

   assign total = base_sel + extra;

endmodule

// File: rtl/mul16_engine.sv
module mul16_engine #(
   parameter int OP_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              sgn,
   input  logic [OP_W-1:0]   mcand_in,
   input  logic [OP_W-1:0]   mplier_in,
   output logic [2*OP_W-1:0] result,
   output logic              running
);
   localparam int P_W   = 2 * OP_W;
   localparam int IDX_W = (OP_W > 1) ? $clog2(OP_W) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(OP_W - 1);

   logic [P_W-1:0]   mcand, acc, acc_next, addend;
   logic [OP_W-1:0]  mplier;
   logic [IDX_W-1:0] idx;
   logic             sgn_q;

   // the top multiplier bit carries negative weight in signed mode
   assign addend   = mplier[0] ? mcand : '0;
   assign acc_next = (sgn_q && idx == LAST) ? acc - addend : acc + addend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mcand   <= '0;
         mplier  <= '0;
         acc     <= '0;
         idx     <= '0;
         sgn_q   <= 1'b0;
         running <= 1'b0;
         result  <= '0;
      end else if (load) begin
         mcand   <= sgn ? {{OP_W{mcand_in[OP_W-1]}}, mcand_in} : {{OP_W{1'b0}}, mcand_in};
         mplier  <= mplier_in;
         acc     <= '0;
         idx     <= '0;
         sgn_q   <= sgn;
         running <= 1'b1;
      end else if (running) begin
         acc    <= acc_next;
         mcand  <= mcand << 1;
         mplier <= mplier >> 1;
         idx    <= idx + 1'b1;
         if (idx == LAST) begin
            running <= 1'b0;
            result  <= acc_next;
         end
      end
   end

   AST_ENGINE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !load && idx == LAST) |=> !running); // R1
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !load) |=> $stable(result)); // R8

endmodule

// File: rtl/mul16_timer.sv
module mul16_timer #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] total,
   output logic             busy,
   output logic             done,
   output logic [CNT_W-1:0] cycles
);
   logic [CNT_W-1:0] rem;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem    <= '0;
         cycles <= '0;
      end else if (load) begin
         rem    <= total;
         cycles <= total;
      end else if (rem != '0) begin
         rem <= rem - 1'b1;
      end
   end

   assign busy = (rem != '0);
   assign done = (rem == CNT_W'(1));

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy); // R9
   AST_CYCLES_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cycles)); // R10

endmodule

// File: rtl/mul16_timed.sv
module mul16_timed
   import mul16_pkg::*;
#(
   parameter int OP_W        = 16,
   parameter int CNT_W       = 7,
   parameter int BASE_OLDEST = 38,
   parameter int BASE_SEC_S  = 32,
   parameter int BASE_SEC_U  = 30,
   parameter int BASE_FLAT   = 27,
   parameter int BIT_COST    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_signed,
   input  logic [1:0]        core_mode,
   input  logic [OP_W-1:0]   src,
   input  logic [OP_W-1:0]   dst,
   output logic [2*OP_W-1:0] product,
   output logic              busy,
   output logic              done,
   output logic [CNT_W-1:0]  cycles
);
   localparam int MAX_BASE = (BASE_OLDEST > BASE_SEC_S)
                             ? ((BASE_OLDEST > BASE_SEC_U) ? BASE_OLDEST : BASE_SEC_U)
                             : ((BASE_SEC_S > BASE_SEC_U) ? BASE_SEC_S : BASE_SEC_U);
   localparam int MAX_LAT  = MAX_BASE + BIT_COST * OP_W;
   localparam int MIN_A    = (BASE_SEC_S < BASE_SEC_U) ? BASE_SEC_S : BASE_SEC_U;
   localparam int MIN_B    = (BASE_OLDEST < BASE_FLAT) ? BASE_OLDEST : BASE_FLAT;
   localparam int MIN_BASE = (MIN_A < MIN_B) ? MIN_A : MIN_B;

   // elaboration checks
   if (MAX_LAT >= (1 << CNT_W)) begin : g_bad_cnt_w
      $error("CNT_W too narrow for the longest latency");
   end
   if (MIN_BASE <= OP_W) begin : g_bad_base
      $error("every base latency must exceed OP_W engine cycles");
   end
   if (OP_W < 2) begin : g_bad_op_w
      $error("OP_W must be at least 2");
   end

   logic             accept;
   logic [CNT_W-1:0] total;
   logic             eng_run;

   assign accept = start && !busy;

   mul16_cost #(
      .OP_W(OP_W), .CNT_W(CNT_W), .BASE_OLDEST(BASE_OLDEST), .BASE_SEC_S(BASE_SEC_S),
      .BASE_SEC_U(BASE_SEC_U), .BASE_FLAT(BASE_FLAT), .BIT_COST(BIT_COST)
   ) u_cost (
      .src   (src),
      .sgn   (is_signed),
      .mode  (core_mode_e'(core_mode)),
      .total (total)
   );

   mul16_engine #(.OP_W(OP_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .sgn       (is_signed),
      .mcand_in  (dst),
      .mplier_in (src),
      .result    (product),
      .running   (eng_run)
   );

   mul16_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .total  (total),
      .busy   (busy),
      .done   (done),
      .cycles (cycles)
   );

   // busy run length, compared against the charged latency when busy drops
   logic [CNT_W:0] run_len;
   always_ff @(posedge clk) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else           run_len <= '0;
   end

   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == {1'b0, cycles})); // R9
   AST_PRODUCT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !eng_run); // R1
   AST_FLAT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && $past(core_mode[1])) |-> (cycles == CNT_W'(BASE_FLAT))); // R6

endmodule

// File: tb/mul16_timed_test.sv
module mul16_timed_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        is_signed = 1'b0;
   logic [1:0]  core_mode = 2'd0;
   logic [15:0] src = '0;
   logic [15:0] dst = '0;
   logic [31:0] product;
   logic        busy, done;
   logic [6:0]  cycles;

   int n_checks = 0;
   int n_fails  = 0;

   always #4 clk = ~clk;

   mul16_timed uut (
      .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
      .core_mode(core_mode), .src(src), .dst(dst), .product(product),
      .busy(busy), .done(done), .cycles(cycles)
   );

   localparam int NV = 8;
   localparam logic [31:0] VEC [NV] = '{
      {16'h0000, 16'h1234},
      {16'hFFFF, 16'hFFFF},
      {16'h8000, 16'h0003},
      {16'h5555, 16'h8001},
      {16'hAAAA, 16'h7FFF},
      {16'h0001, 16'hFFFF},
      {16'h7FFF, 16'h8000},
      {16'h00F0, 16'h0F0F}
   };

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_lat(input logic [1:0] m, input bit sg, input logic [15:0] s);
      int  n = 0;
      bit  prev = 1'b0;
      if (m >= 2) return 27;
      for (int i = 0; i < 16; i++) begin
         if (sg) begin
            if (s[i] != prev) n++;
            prev = s[i];
         end else if (s[i]) n++;
      end
      if (m == 0) return 38 + 2 * n;
      return (sg ? 32 : 30) + 2 * n;
   endfunction

   function automatic logic [31:0] exp_prod(input bit sg, input logic [15:0] s, input logic [15:0] d);
      longint a, b;
      a = sg ? longint'($signed(s)) : longint'(s);
      b = sg ? longint'($signed(d)) : longint'(d);
      return 32'(a * b);
   endfunction

   function automatic string lat_req(input logic [1:0] m, input bit sg);
      if (m == 0) return sg ? "R4" : "R3";
      if (m == 1) return "R5";
      return "R6";
   endfunction

   task automatic launch(input logic [1:0] m, input bit sg, input logic [15:0] s, input logic [15:0] d);
      @(negedge clk);
      start = 1'b1; core_mode = m; is_signed = sg; src = s; dst = d;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic measure(output int len, output int dcnt, output int dat);
      len = 0; dcnt = 0; dat = -1;
      while (busy && len < 300) begin
         if (done) begin dcnt++; dat = len; end
         len++;
         @(negedge clk);
      end
   endtask

   task automatic run_op(input logic [1:0] m, input bit sg, input logic [15:0] s, input logic [15:0] d);
      int n, len, dcnt, dat;
      n = exp_lat(m, sg, s);
      launch(m, sg, s, d);
      check(cycles == 7'(n), "R8 cycles", cycles, n);
      measure(len, dcnt, dat);
      check(len == n, lat_req(m, sg), len, n);
      check(dcnt == 1 && dat == n - 1, "R9 done position", dat, n - 1);
      check(product == exp_prod(sg, s, d), sg ? "R2 product" : "R1 product",
            product, exp_prod(sg, s, d));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      int len, dcnt, dat, c1;
      // R12: reset state
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R12 busy", busy, 0);
      check(done == 1'b0, "R12 done", done, 0);
      check(product == '0, "R12 product", product, 0);
      check(cycles == '0, "R12 cycles", cycles, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: every entry in every mode and signedness
      for (int v = 0; v < NV; v++)
         for (int m = 0; m < 4; m++)
            for (int sg = 0; sg < 2; sg++)
               run_op(2'(m), 1'(sg), VEC[v][31:16], VEC[v][15:0]);

      // R13: zero source gives base latency and zero product
      run_op(2'd0, 1'b1, 16'h0000, 16'hBEEF);
      check(cycles == 7'd38 && product == '0, "R13 signed zero src", cycles, 38);
      run_op(2'd1, 1'b0, 16'h0000, 16'hBEEF);
      check(cycles == 7'd30 && product == '0, "R13 unsigned zero src", cycles, 30);

      // R7: dst has no effect on latency
      run_op(2'd0, 1'b0, 16'h00F0, 16'h0000);
      c1 = int'(cycles);
      run_op(2'd0, 1'b0, 16'h00F0, 16'hFFFF);
      check(int'(cycles) == c1 && c1 == 46, "R7 dst independence", cycles, c1);

      // R10: start during busy is ignored
      launch(2'd0, 1'b0, 16'h0003, 16'h0005);
      repeat (4) @(negedge clk);
      start = 1'b1; core_mode = 2'd2; is_signed = 1'b1; src = 16'hFFFF; dst = 16'hFFFF;
      @(negedge clk);
      start = 1'b0;
      check(cycles == 7'd42, "R10 cycles after ignored start", cycles, 42);
      measure(len, dcnt, dat);
      check(len + 5 == 42, "R10 busy length", len + 5, 42);
      check(product == 32'd15, "R10 product", product, 15);
      repeat (3) begin
         check(busy == 1'b0, "R10 no second operation", busy, 0);
         @(negedge clk);
      end

      // R11: inputs changed after capture
      launch(2'd0, 1'b0, 16'h000F, 16'h0003);
      core_mode = 2'd2; is_signed = 1'b1; src = 16'h5555; dst = 16'hFFFF;
      measure(len, dcnt, dat);
      check(len == 46, "R11 latency kept", len, 46);
      check(product == 32'd45, "R11 product kept", product, 45);
      check(cycles == 7'd46, "R11 cycles kept", cycles, 46);

      // random operands across all modes
      for (int r = 0; r < 40; r++)
         run_op(2'($urandom_range(3)), 1'($urandom_range(1)),
                16'($urandom), 16'($urandom));

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule